// File: doc/BRIEF.md
# Bridge Exclusive Access Lock Controller

This block follows a bus-lock (exclusive access) sequence that an initiator runs through a two-port bridge toward the target bus. On each transaction start it decodes the command, the direction and the initiator lock signal. It decides whether a lock may be opened and reports the target completion back to the initiator. It drives the target-side lock signal and tells the rest of the bridge when ordinary unlocked traffic may be forwarded again.

A lock can be opened only by a memory read that travels downstream. Any other command that tries to open a lock is answered with a master-abort request. Lock attempts that travel upstream are treated as ordinary traffic. After the opening read completes normally, the target-side lock stays asserted through every later locked transaction, including retried ones. It drops only after the initiator has released both lock and frame. If the final transaction was a posted write that has not yet finished on the target bus, the release waits for that completion.

Top module: `xlock_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tgt_lock_n` is 1, `fwd_en` is 1, `mabort_req` is 0 and `init_status_vld` is 0.
- R2: From idle, a start with `txn_up`=0, `init_lock_n`=0 and `txn_cmd`=4'b0110 (memory read) drives `tgt_lock_n` to 0 and `fwd_en` to 0 on the next cycle.
- R3: From idle, a downstream start with `init_lock_n`=0 and any other command (for example 4'b0111 memory write or 4'b0010 I/O read) pulses `mabort_req` high for one cycle and leaves `tgt_lock_n` at 1.
- R4: A start with `txn_up`=1 never opens a lock and never raises `mabort_req`.
- R5: If the opening read completes with `tgt_status` 2 (target abort) or 3 (master abort), the next cycle returns that code on `init_status` with `init_status_vld`=1, and `tgt_lock_n` returns to 1.
- R6: If the opening read completes with `tgt_status` 1 (retry), `tgt_lock_n` returns to 1 on the next cycle.
- R7: Once locked, a completion of any code, including retry (1), leaves `tgt_lock_n` at 0.
- R8: In the locked state, with no posted write outstanding, sampling `init_lock_n`=1 and `init_frame_n`=1 together sets `tgt_lock_n` to 1 on the next cycle.
- R9: If a posted write (`txn_posted`=1) is still outstanding when the initiator releases, `tgt_lock_n` stays 0 until that write's `tgt_done`, and becomes 1 on the following cycle.
- R10: A `tgt_done` while a lock sequence is active (opening, locked or release pending) yields `init_status_vld`=1 on the next cycle, with `init_status` equal to the `tgt_status` code (0 normal, 1 retry, 2 target abort, 3 master abort).
- R11: `fwd_en` is 0 exactly while `tgt_lock_n` is 0.
- R12: In the locked state, the lock holds while either `init_lock_n` or `init_frame_n` is sampled 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| txn_start | input | 1 | One-cycle strobe marking a new initiator transaction |
| txn_cmd | input | CMD_W | Bus command code of the starting transaction |
| txn_up | input | 1 | 1 when the transaction travels upstream |
| txn_posted | input | 1 | 1 for a posted write, 0 for a delayed transaction |
| init_lock_n | input | 1 | Initiator-side lock, active low |
| init_frame_n | input | 1 | Initiator-side frame, active low |
| tgt_done | input | 1 | One-cycle strobe: a target-bus transaction completed |
| tgt_status | input | 2 | Completion code: 0 normal, 1 retry, 2 target abort, 3 master abort |
| tgt_lock_n | output | 1 | Registered target-side lock, active low |
| mabort_req | output | 1 | One-cycle request to master-abort an illegal lock opener |
| init_status_vld | output | 1 | Completion status returned to the initiator is valid |
| init_status | output | 2 | Returned completion code |
| fwd_en | output | 1 | Unlocked transactions may be forwarded |

## Verification
A wrong internal state shows at the ports one cycle after the input that exposes it. A lock that was dropped early shows as `tgt_lock_n` and `fwd_en` going high during a retried or still-pending locked transaction. A machine that is stuck locked shows as `tgt_lock_n` staying low after a clean release. A machine that thinks it is idle while a sequence is open shows as a missing `init_status_vld`, or as a stray `mabort_req` on the next locked start. The bench runs a cycle model beside the block and compares every output on every cycle, so any divergence is reported on the cycle it first appears.

// File: rtl/xlock_pkg.sv
package xlock_pkg;
  typedef enum logic [2:0] {
    LK_IDLE   = 3'd0,
    LK_FIRST  = 3'd1,
    LK_HELD   = 3'd2,
    LK_DRAIN  = 3'd3,
    LK_ABORT  = 3'd4
  } lk_state_e;

  localparam logic [1:0] CPL_OK     = 2'd0;
  localparam logic [1:0] CPL_RETRY  = 2'd1;
  localparam logic [1:0] CPL_TABORT = 2'd2;
  localparam logic [1:0] CPL_MABORT = 2'd3;

  function automatic logic seq_active(lk_state_e s);
    return (s == LK_FIRST) || (s == LK_HELD) || (s == LK_DRAIN);
  endfunction
endpackage

// File: rtl/xlock_decode.sv
module xlock_decode #(
  parameter int          CMD_W    = 4,
  parameter logic [3:0]  OPEN_CMD = 4'b0110
) (
  input  logic             txn_start,
  input  logic [CMD_W-1:0] txn_cmd,
  input  logic             txn_up,
  input  logic             init_lock_n,
  output logic             open_ok,
  output logic             open_bad
);
  localparam logic [CMD_W-1:0] OPEN_CODE = CMD_W'(OPEN_CMD);

  logic down_lock;

  always_comb begin
    down_lock = txn_start && !txn_up && !init_lock_n;
    open_ok   = down_lock && (txn_cmd == OPEN_CODE);
    open_bad  = down_lock && (txn_cmd != OPEN_CODE);
  end
endmodule

// File: rtl/xlock_fsm.sv
module xlock_fsm
  import xlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      open_ok,
  input  logic      txn_start,
  input  logic      txn_up,
  input  logic      txn_posted,
  input  logic      init_lock_n,
  input  logic      init_frame_n,
  input  logic      tgt_done,
  input  logic [1:0] tgt_status,
  output lk_state_e st_q,
  output lk_state_e st_d
);
  logic pend_q, pend_d;
  logic released;

  always_comb begin
    released = init_lock_n && init_frame_n;
    st_d     = st_q;
    pend_d   = 1'b0;
    unique case (st_q)
      LK_IDLE, LK_ABORT: st_d = open_ok ? LK_FIRST : LK_IDLE;
      LK_FIRST: begin
        if (tgt_done) begin
          unique case (tgt_status)
            CPL_OK:    st_d = LK_HELD;
            CPL_RETRY: st_d = LK_IDLE;
            default:   st_d = LK_ABORT;
          endcase
        end
      end
      LK_HELD: begin
        pend_d = pend_q;
        if (tgt_done) pend_d = 1'b0;
        if (txn_start && !txn_up) pend_d = txn_posted;
        if (released) st_d = pend_d ? LK_DRAIN : LK_IDLE;
      end
      LK_DRAIN: begin
        pend_d = !tgt_done;
        if (tgt_done) st_d = LK_IDLE;
      end
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LK_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // R9
  drain_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == LK_DRAIN && !tgt_done) |=> (st_q == LK_DRAIN));
endmodule

// File: rtl/xlock_outreg.sv
module xlock_outreg
  import xlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lk_state_e  st_q,
  input  lk_state_e  st_d,
  input  logic       open_bad,
  input  logic       tgt_done,
  input  logic [1:0] tgt_status,
  output logic       tgt_lock_n,
  output logic       fwd_en,
  output logic       mabort_req,
  output logic       init_status_vld,
  output logic [1:0] init_status
);
  logic hold_next, idle_now;

  always_comb begin
    hold_next = seq_active(st_d);
    idle_now  = (st_q == LK_IDLE) || (st_q == LK_ABORT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lock_n      <= 1'b1;
      fwd_en          <= 1'b1;
      mabort_req      <= 1'b0;
      init_status_vld <= 1'b0;
      init_status     <= CPL_OK;
    end else begin
      tgt_lock_n      <= !hold_next;
      fwd_en          <= !hold_next;
      mabort_req      <= idle_now && open_bad;
      init_status_vld <= tgt_done && seq_active(st_q);
      if (tgt_done && seq_active(st_q)) init_status <= tgt_status;
    end
  end

  // R3
  mabort_nolock_chk: assert property (@(posedge clk) disable iff (rst)
    mabort_req |-> tgt_lock_n);
endmodule

// File: rtl/xlock_ctrl.sv
module xlock_ctrl
  import xlock_pkg::*;
#(
  parameter int         CMD_W    = 4,
  parameter logic [3:0] OPEN_CMD = 4'b0110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic [CMD_W-1:0] txn_cmd,
  input  logic             txn_up,
  input  logic             txn_posted,
  input  logic             init_lock_n,
  input  logic             init_frame_n,
  input  logic             tgt_done,
  input  logic [1:0]       tgt_status,
  output logic             tgt_lock_n,
  output logic             mabort_req,
  output logic             init_status_vld,
  output logic [1:0]       init_status,
  output logic             fwd_en
);
  logic      open_ok, open_bad;
  lk_state_e st_q, st_d;

  xlock_decode #(.CMD_W(CMD_W), .OPEN_CMD(OPEN_CMD)) u_decode (
    .txn_start  (txn_start),
    .txn_cmd    (txn_cmd),
    .txn_up     (txn_up),
    .init_lock_n(init_lock_n),
    .open_ok    (open_ok),
    .open_bad   (open_bad)
  );

  xlock_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .open_ok     (open_ok),
    .txn_start   (txn_start),
    .txn_up      (txn_up),
    .txn_posted  (txn_posted),
    .init_lock_n (init_lock_n),
    .init_frame_n(init_frame_n),
    .tgt_done    (tgt_done),
    .tgt_status  (tgt_status),
    .st_q        (st_q),
    .st_d        (st_d)
  );

  xlock_outreg u_out (
    .clk            (clk),
    .rst            (rst),
    .st_q           (st_q),
    .st_d           (st_d),
    .open_bad       (open_bad),
    .tgt_done       (tgt_done),
    .tgt_status     (tgt_status),
    .tgt_lock_n     (tgt_lock_n),
    .fwd_en         (fwd_en),
    .mabort_req     (mabort_req),
    .init_status_vld(init_status_vld),
    .init_status    (init_status)
  );

  // R2
  open_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LK_IDLE) && txn_start && !txn_up && !init_lock_n && txn_cmd == CMD_W'(OPEN_CMD))
      |=> (!tgt_lock_n && !fwd_en));

  // R4
  upstream_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LK_IDLE) && txn_start && txn_up) |=> (tgt_lock_n && !mabort_req));

  // R7
  held_retry_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LK_HELD) && tgt_done && !(init_lock_n && init_frame_n)) |=> !tgt_lock_n);

  // R10
  status_return_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_done && seq_active(st_q)) |=> (init_status_vld && init_status == $past(tgt_status)));

  // R11
  fwd_match_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_en == tgt_lock_n);

  // R12
  held_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LK_HELD) && (!init_lock_n || !init_frame_n)) |=> !tgt_lock_n);
endmodule

// File: tb/xlock_ctrl_bench.sv
`timescale 1ns/1ps
module xlock_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       txn_start, txn_up, txn_posted, init_lock_n, init_frame_n, tgt_done;
  logic [3:0] txn_cmd;
  logic [1:0] tgt_status;
  logic       tgt_lock_n, mabort_req, init_status_vld, fwd_en;
  logic [1:0] init_status;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  int m_st = 0;
  bit m_pend = 0;

  always #2.5 clk = ~clk;

  xlock_ctrl u_xlock_ctrl (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_cmd(txn_cmd), .txn_up(txn_up),
    .txn_posted(txn_posted), .init_lock_n(init_lock_n), .init_frame_n(init_frame_n),
    .tgt_done(tgt_done), .tgt_status(tgt_status), .tgt_lock_n(tgt_lock_n),
    .mabort_req(mabort_req), .init_status_vld(init_status_vld),
    .init_status(init_status), .fwd_en(fwd_en)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit active(int s);
    return s == 1 || s == 2 || s == 3;
  endfunction

  // one cycle: model next expected outputs, clock, compare, clear strobes
  task automatic cyc(string tag);
    int ns = m_st;
    bit p = 1'b0;
    bit dls, ok, bad, idle_now, e_mab, e_vld;
    int e_stat;
    dls = txn_start && !txn_up && !init_lock_n;
    ok  = dls && (txn_cmd == 4'b0110);
    bad = dls && (txn_cmd != 4'b0110);
    idle_now = (m_st == 0) || (m_st == 4);
    case (m_st)
      0, 4: ns = ok ? 1 : 0;
      1: if (tgt_done) ns = (tgt_status == 0) ? 2 : (tgt_status == 1) ? 0 : 4;
      2: begin
        p = m_pend;
        if (tgt_done) p = 1'b0;
        if (txn_start && !txn_up) p = txn_posted;
        if (init_lock_n && init_frame_n) ns = p ? 3 : 0;
      end
      3: begin p = !tgt_done; if (tgt_done) ns = 0; end
      default: ns = 0;
    endcase
    e_mab  = idle_now && bad;
    e_vld  = tgt_done && active(m_st);
    e_stat = tgt_status;
    m_st = ns; m_pend = p;
    @(posedge clk); #1;
    chk(tag, "tgt_lock_n", tgt_lock_n, !active(m_st));
    chk("R11", "fwd_en", fwd_en, !active(m_st));
    chk(tag, "mabort_req", mabort_req, e_mab);
    chk(tag, "init_status_vld", init_status_vld, e_vld);
    if (e_vld) chk("R10", "init_status", init_status, e_stat);
    txn_start = 0; tgt_done = 0;
  endtask

  task automatic start(logic [3:0] cmd, bit up, bit posted);
    txn_start = 1; txn_cmd = cmd; txn_up = up; txn_posted = posted;
    init_lock_n = 0; init_frame_n = 0;
  endtask

  task automatic done(logic [1:0] s);
    tgt_done = 1; tgt_status = s;
  endtask

  task automatic idle_bus();
    init_lock_n = 1; init_frame_n = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; txn_start = 0; txn_cmd = 0; txn_up = 0; txn_posted = 0;
    init_lock_n = 1; init_frame_n = 1; tgt_done = 0; tgt_status = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "tgt_lock_n", tgt_lock_n, 1);
    chk("R1", "fwd_en", fwd_en, 1);
    chk("R1", "mabort_req", mabort_req, 0);
    chk("R1", "init_status_vld", init_status_vld, 0);
    rst = 0;
    cyc("R1");

    // R2 open, R10 normal status, R7 retry while held, R12, R8 release
    start(4'b0110, 0, 0); cyc("R2");
    done(0); cyc("R10");
    start(4'b0010, 0, 0); cyc("R7");
    done(1); cyc("R7");
    init_lock_n = 0; init_frame_n = 1; cyc("R12");
    init_lock_n = 1; init_frame_n = 0; cyc("R12");
    idle_bus(); cyc("R8");
    cyc("R8");

    // R3 illegal openers
    start(4'b0111, 0, 0); cyc("R3");
    idle_bus(); cyc("R3");
    start(4'b0010, 0, 0); cyc("R3");
    start(4'b1010, 0, 0); cyc("R3");
    idle_bus(); cyc("R3");

    // R4 upstream lock ignored
    start(4'b0110, 1, 0); cyc("R4");
    start(4'b0111, 1, 0); cyc("R4");
    idle_bus(); cyc("R4");

    // R6 retry on opener
    start(4'b0110, 0, 0); cyc("R6");
    done(1); cyc("R6");
    idle_bus(); cyc("R6");

    // R5 target abort and master abort on opener
    start(4'b0110, 0, 0); cyc("R5");
    done(2); cyc("R5");
    idle_bus(); cyc("R5");
    start(4'b0110, 0, 0); cyc("R5");
    done(3); cyc("R5");
    idle_bus(); cyc("R5");

    // R9 posted write outstanding at release
    start(4'b0110, 0, 0); cyc("R9");
    done(0); cyc("R9");
    start(4'b0111, 0, 1); cyc("R9");
    idle_bus(); cyc("R9");
    repeat (4) cyc("R9");
    done(0); cyc("R9");
    cyc("R9");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      txn_start    = ($urandom % 100) < 30;
      txn_cmd      = (($urandom % 2) == 0) ? 4'b0110 : 4'($urandom);
      txn_up       = ($urandom % 100) < 15;
      txn_posted   = ($urandom % 100) < 40;
      init_lock_n  = ($urandom % 100) < 30;
      init_frame_n = ($urandom % 100) < 50;
      tgt_done     = ($urandom % 100) < 25;
      tgt_status   = 2'($urandom);
      cyc("R10/R11 random");
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule